// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous on-chip bus and an external asynchronous static RAM of 256K words by 16 bits that has separate lower and upper byte enables. Each accepted request is one word read or one word write. The controller turns it into a strobe sequence whose phase lengths are whole clock counts. These counts are worked out offline from the RAM's nanosecond limits: read cycles from the read cycle time, write-low cycles from the write pulse width, and turnaround cycles from the output-disable time.

On the internal side, a request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the whole access is over, including the gap after a read in which the RAM releases the bus. Read data returns with a one-cycle `rsp_valid` pulse. The external data bus is split into an input, an output and a drive enable, so a pad ring or a bench can resolve it.

Top module: `sram_ctrl`

## Requirements
- R1: During an access, `ram_addr` carries the 18-bit word address of the accepted request and holds it steady while chip enable is low. `ram_lb_n` is low exactly when `req_mask[0]` was 1, and `ram_ub_n` is low exactly when `req_mask[1]` was 1. A mask bit of 1 enables its lane: bit 0 is data 7:0 and bit 1 is data 15:8.
- R2: After reset and whenever `req_ready` is high, chip enable, output enable and write enable are all high, `ram_dq_oe` is low and `rsp_valid` is low.
- R3: A read holds chip enable and output enable low, with write enable high, for RD_CYC cycles. The data bus is sampled on the last of these edges. `rsp_valid` then pulses for exactly one cycle, and lanes that were not enabled return as zero.
- R4: A write has three phases. First comes one setup cycle, with chip enable low, write enable high and the data driven. Then write enable is low for WR_LOW_CYC cycles while the data stays stable. Last comes one hold cycle with chip enable still low. Output enable stays high for the whole write.
- R5: A write changes only the lanes whose mask bit is 1. A write with mask 2'b00 changes no stored data.
- R6: The controller never drives the data bus while output enable is low. After a read, at least TA_CYC cycles with chip enable and output enable high pass before it drives again.
- R7: `req_ready` is low for exactly RD_CYC+TA_CYC cycles after a read is accepted, and for exactly WR_LOW_CYC+2 cycles after a write is accepted.
- R8: A request presented while `req_ready` is low is not accepted and has no effect on the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 18 | RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_lb_n | output | 1 | RAM low byte enable, active low |
| ram_ub_n | output | 1 | RAM high byte enable, active low |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | 16 | Data received from the RAM |

## Verification
The bench builds the block with RD_CYC=3, WR_LOW_CYC=2 and TA_CYC=2. These short counts still leave every phase longer than one cycle, so a capture made one edge early, a write-enable pulse that is one cycle short, or a bus drive that starts inside the release window all become visible to the RAM model. The model returns a poison word until the access time has passed, and it keeps the read lanes that were not enabled non-zero.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSETUP,
    ST_WLOW,
    ST_WHOLD
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } strobe_t;

  function automatic strobe_t decode_strobe(state_e s);
    strobe_t r;
    r.ce_n  = !(s == ST_RD || s == ST_WSETUP || s == ST_WLOW || s == ST_WHOLD);
    r.oe_n  = (s != ST_RD);
    r.we_n  = (s != ST_WLOW);
    r.drive = (s == ST_WSETUP || s == ST_WLOW || s == ST_WHOLD);
    return r;
  endfunction
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC     = 9,
  parameter int WR_LOW_CYC = 7,
  parameter int TA_CYC     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ram_ce_n,
  output logic ram_oe_n,
  output logic ram_we_n,
  output logic ram_dq_oe
);
  localparam int MAXC = (RD_CYC > WR_LOW_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                              : ((WR_LOW_CYC > TA_CYC) ? WR_LOW_CYC : TA_CYC);
  localparam int CW = $clog2(MAXC + 1);

  state_e        state_q, state_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;
  strobe_t       stb_q, stb_nxt;
  logic          ready_nxt;

  assign accept  = req_valid && req_ready;
  assign capture = (state_q == ST_RD) && (cnt_q == '0);

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    cnt_en    = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        cnt_en = 1'b1;
        if (req_we) begin
          state_nxt = ST_WSETUP;
          cnt_nxt   = '0;
        end else begin
          state_nxt = ST_RD;
          cnt_nxt   = CW'(RD_CYC - 1);
        end
      end
      ST_RD: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          state_nxt = ST_TURN;
          cnt_nxt   = CW'(TA_CYC - 1);
        end else cnt_nxt = cnt_q - 1'b1;
      end
      ST_TURN: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) state_nxt = ST_IDLE;
        else cnt_nxt = cnt_q - 1'b1;
      end
      ST_WSETUP: begin
        cnt_en    = 1'b1;
        state_nxt = ST_WLOW;
        cnt_nxt   = CW'(WR_LOW_CYC - 1);
      end
      ST_WLOW: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) state_nxt = ST_WHOLD;
        else cnt_nxt = cnt_q - 1'b1;
      end
      ST_WHOLD: state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
    stb_nxt   = decode_strobe(state_nxt);
    ready_nxt = (state_nxt == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stb_q     <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      req_ready <= 1'b1;
    end else begin
      state_q   <= state_nxt;
      stb_q     <= stb_nxt;
      req_ready <= ready_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign ram_ce_n  = stb_q.ce_n;
  assign ram_oe_n  = stb_q.oe_n;
  assign ram_we_n  = stb_q.we_n;
  assign ram_dq_oe = stb_q.drive;

  assert_we_in_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && ram_oe_n && ram_dq_oe));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe));

  assert_read_leaves_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> !ram_dq_oe);
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int AW = 18,
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_mask,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] ram_addr,
  output logic [NB-1:0] ram_be_n,
  output logic [DW-1:0] ram_dq_o,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] mask_q;
  logic [DW-1:0] lane_keep;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_keep[b*8 +: 8] = {8{mask_q[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= ram_dq_i & lane_keep;
    end
  end

  assign ram_addr = addr_q;
  assign ram_be_n = ~mask_q;
  assign ram_dq_o = wdata_q;

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int RD_CYC     = 9,
  parameter int WR_LOW_CYC = 7,
  parameter int TA_CYC     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_we,
  input  logic [17:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_mask,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic [17:0] ram_addr,
  output logic        ram_ce_n,
  output logic        ram_oe_n,
  output logic        ram_we_n,
  output logic        ram_lb_n,
  output logic        ram_ub_n,
  output logic [15:0] ram_dq_o,
  output logic        ram_dq_oe,
  input  logic [15:0] ram_dq_i
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       accept, capture;
  logic [1:0] be_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC), .WR_LOW_CYC(WR_LOW_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_s_n), .req_valid(req_valid), .req_we(req_we),
    .req_ready(req_ready), .accept(accept), .capture(capture),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_oe(ram_dq_oe)
  );

  sram_ctrl_dpath #(.AW(18), .DW(16)) u_dpath (
    .clk(clk), .rst_n(rst_s_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ram_dq_i(ram_dq_i), .ram_addr(ram_addr), .ram_be_n(be_n),
    .ram_dq_o(ram_dq_o), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign ram_lb_n = be_n[0];
  assign ram_ub_n = be_n[1];

  assert_no_drive_in_read_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ram_oe_n |-> !ram_dq_oe);

  assert_addr_steady_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_ready |=> ($stable(ram_addr) && $stable(ram_dq_o)));
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int RD = 3;
  localparam int WL = 2;
  localparam int TA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] ram_addr;
  logic ram_ce_n, ram_oe_n, ram_we_n, ram_lb_n, ram_ub_n, ram_dq_oe;
  logic [15:0] ram_dq_o;
  logic [15:0] ram_dq_i = 16'hDEAD;

  int checks = 0, failures = 0;
  int wviol = 0, cviol = 0, iviol = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_ctrl #(.RD_CYC(RD), .WR_LOW_CYC(WL), .TA_CYC(TA)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n), .ram_dq_o(ram_dq_o),
    .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  // RAM model, clock-unit timing checks
  logic [15:0] mem [64];
  int rd_cnt = 0, wl_cnt = 0, rel = 0;
  logic [15:0] wl_data;
  bit we_was_low = 0;
  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    bit rd_act;
    logic [15:0] w;
    if (rst_n) begin
      rd_act = !ram_ce_n && !ram_oe_n && ram_we_n;
      if (ram_dq_oe && (rd_act || rel > 0)) cviol++;
      if (rd_act) rel = TA; else if (rel > 0) rel--;
      if (req_ready && !(ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe)) iviol++;
      if (!ram_ce_n && !ram_we_n) begin
        if (wl_cnt == 0) wl_data = ram_dq_o;
        else if (ram_dq_o != wl_data) wviol++;
        if (!ram_dq_oe || !ram_oe_n) wviol++;
        wl_cnt++;
      end else if (we_was_low) begin
        if (wl_cnt < WL || ram_ce_n) wviol++;
        w = mem[ram_addr[5:0]];
        if (!ram_lb_n) w[7:0]  = wl_data[7:0];
        if (!ram_ub_n) w[15:8] = wl_data[15:8];
        mem[ram_addr[5:0]] = w;
        wl_cnt = 0;
      end
      we_was_low = !ram_we_n;
      if (rd_act) rd_cnt++; else rd_cnt = 0;
      if (rd_cnt >= RD)
        ram_dq_i = {ram_ub_n ? 8'hEE : mem[ram_addr[5:0]][15:8],
                    ram_lb_n ? 8'hEE : mem[ram_addr[5:0]][7:0]};
      else ram_dq_i = 16'hDEAD;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input bit we, input logic [1:0] mask, input logic [17:0] addr,
                     input logic [15:0] wd, input logic [15:0] exp, input bit poke);
    int busy = 0, pulses = 0, guard = 0;
    logic [15:0] got = '0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_valid = 1; req_we = we; req_addr = addr; req_wdata = wd; req_mask = mask;
    @(negedge clk);
    req_valid = 0;
    chk(ram_addr == addr, "R1 address", ram_addr, addr);
    chk({!ram_ub_n, !ram_lb_n} == mask, "R1 byte enables", {!ram_ub_n, !ram_lb_n}, mask);
    while (!req_ready && guard < 100) begin
      busy++; guard++;
      if (rsp_valid) begin pulses++; got = rsp_rdata; end
      if (ram_dq_oe && !ram_oe_n) chk(0, "R6 drive during read", 1, 0);
      if (poke && busy == 1) begin
        req_valid = 1; req_we = 1; req_addr = 18'h00000; req_wdata = 16'hFFFF; req_mask = 2'b11;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    if (we) begin
      chk(busy == WL + 2, "R7 write busy", busy, WL + 2);
      chk(pulses == 0, "R3 no rsp on write", pulses, 0);
    end else begin
      chk(busy == RD + TA, "R7 read busy", busy, RD + TA);
      chk(pulses == 1, "R3 one rsp pulse", pulses, 1);
      chk(got == exp, "R3 R5 read data", got, exp);
    end
  endtask

  // {we, mask, addr, wdata, expected}
  localparam logic [52:0] VEC [12] = '{
    {1'b1, 2'b11, 18'h00005, 16'hA1B2, 16'h0000},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA1B2},
    {1'b1, 2'b01, 18'h00005, 16'h00CD, 16'h0000},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA1CD},
    {1'b1, 2'b10, 18'h3FFFF, 16'h7766, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'h7700},
    {1'b0, 2'b10, 18'h00005, 16'h0000, 16'hA100},
    {1'b0, 2'b01, 18'h00005, 16'h0000, 16'h00CD},
    {1'b1, 2'b00, 18'h00005, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA1CD},
    {1'b1, 2'b11, 18'h00000, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 18'h00000, 16'h0000, 16'h1234}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready && ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe && !rsp_valid,
        "R2 reset state", {req_ready, ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe, rsp_valid}, 6'b111100);
    for (int i = 0; i < 12; i++)
      txn(VEC[i][52], VEC[i][51:50], VEC[i][49:32], VEC[i][31:16], VEC[i][15:0], 0);
    // R8: write offered while busy with a read must be ignored
    txn(0, 2'b11, 18'h00000, 16'h0000, 16'h1234, 1);
    txn(0, 2'b11, 18'h00000, 16'h0000, 16'h1234, 0);
    // R6: write right after a read, bus turnaround
    txn(0, 2'b01, 18'h3FFFF, 16'h0000, 16'h0000, 0);
    txn(1, 2'b11, 18'h3FFFF, 16'hBEEF, 16'h0000, 0);
    txn(0, 2'b11, 18'h3FFFF, 16'h0000, 16'hBEEF, 0);
    repeat (3) @(negedge clk);
    chk(cviol == 0, "R6 bus contention", cviol, 0);
    chk(wviol == 0, "R4 write timing", wviol, 0);
    chk(iviol == 0, "R2 idle strobes", iviol, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule